// File: doc/BRIEF.md
# Newline-Framed Text Line Capture

This block gathers a stream of 8-bit text characters into a row buffer, one character per valid strobe. When the line-feed character arrives, it releases the whole row at once as one wide parallel word. In the same cycle it raises a one-clock start pulse, so that a downstream row processor can take the row without any handshake. The row processor might be, for example, a unit that updates every grid column in parallel.

Alongside the raw characters, the block also presents a small per-column cell code. With it, consumers can see empty cells, source cells and splitter cells without decoding the characters themselves. Carriage returns are dropped, so text with CR LF line endings frames the same way as text with bare LF endings. Characters beyond the row width are thrown away, and a sticky flag records that this happened. Idle cycles between characters may be of any length.

Top module: `line_capture`

## Requirements
- R1: After reset, `line_o` holds 0x2E (`.`) in every column, `cell_o` is all zeros, and `start_o` and `ovf_o` are low.
- R2: Each byte taken with `byte_vld_i` high that is neither 0x0A nor 0x0D goes to the next free column. The first byte of a line is column 0. Column c occupies bits [8c+7:8c] of `line_o`.
- R3: A byte 0x0A taken at a clock edge makes `start_o` high for exactly the following cycle. In that same cycle `line_o` shows the completed line. The 0x0A itself is not stored, and every line fed produces exactly one start pulse.
- R4: Between start pulses, `line_o` and `cell_o` keep the value of the last completed line.
- R5: After a line completes, the next line fills from column 0 again. Any column not written in a line reads 0x2E, including columns that held characters in the previous line.
- R6: A byte 0x0D is ignored: it is not stored and does not advance the column.
- R7: Cycles with `byte_vld_i` low, of any number, change neither the row being gathered nor the outputs.
- R8: With 256 columns, bytes after the 256th stored character of a line are discarded and set `ovf_o`. A line of exactly 256 characters does not set it. `ovf_o` stays high until reset, and a 0x0A still completes the truncated line.
- R9: `cell_o` carries 2 bits per column at [2c+1:2c]. The code is 0 for `.` (0x2E), 1 for `S` (0x53), 2 for `^` (0x5E) and 3 for any other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| byte_i | input | 8 | Incoming character |
| byte_vld_i | input | 1 | Qualifies `byte_i` for one cycle |
| line_o | output | 2048 | Last completed line, column 0 in the low byte |
| cell_o | output | 512 | Per-column 2-bit cell code of `line_o` |
| start_o | output | 1 | One-cycle pulse when `line_o` carries a new line |
| ovf_o | output | 1 | Sticky flag: a line exceeded the column count |

## Verification
The bench sends back-to-back lines, lines with long idle gaps, and lines broken by a long pause. If a design let idle cycles leak through, it would repeat characters or start a spurious row. It follows a long line with a short one and also sends an empty line. A design that skipped clearing would then show stale characters in the tail columns. Embedded and trailing carriage returns are sent to catch a design that stores them or lets them shift every later character. Lines of exactly 256 and of 300 characters separate an off-by-one at the width limit from correct truncation. A later line then confirms that the overflow flag stays set.

// File: rtl/line_cap_pkg.sv
package line_cap_pkg;

    localparam int CHR_W  = 8;
    localparam int CELL_W = 2;

    localparam logic [CHR_W-1:0] LF_CHR = 8'h0A;
    localparam logic [CHR_W-1:0] CR_CHR = 8'h0D;

    // Column classification handed to the row processor
    typedef enum logic [CELL_W-1:0] {
        CELL_EMPTY  = 2'd0,
        CELL_SOURCE = 2'd1,
        CELL_SPLIT  = 2'd2,
        CELL_OTHER  = 2'd3
    } cell_e;

endpackage

// File: rtl/lc_ctrl.sv
module lc_ctrl
    import line_cap_pkg::*;
#(
    parameter  int COLS  = 256,
    localparam int IDX_W = $clog2(COLS + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CHR_W-1:0] byte_i,
    input  logic             byte_vld_i,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic             flush_o,
    output logic             start_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             ovf;
        logic             start;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic is_lf;
    logic is_cr;
    logic is_dat;
    logic room;

    always_comb begin
        is_lf  = byte_vld_i && (byte_i == LF_CHR);
        is_cr  = byte_vld_i && (byte_i == CR_CHR);
        is_dat = byte_vld_i && !is_lf && !is_cr;
        room   = (st_q.idx < IDX_W'(COLS));

        st_d       = st_q;
        st_d.start = is_lf;
        wr_en_o    = is_dat && room;
        flush_o    = is_lf;

        if (is_lf) begin
            st_d.idx = '0;
        end else if (wr_en_o) begin
            st_d.idx = st_q.idx + 1'b1;
        end

        // a printable byte arriving with no column left is lost
        if (is_dat && !room) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_idx_o = st_q.idx;
    assign start_o  = st_q.start;
    assign ovf_o    = st_q.ovf;

endmodule

// File: rtl/lc_store.sv
module lc_store
    import line_cap_pkg::*;
#(
    parameter  int               COLS      = 256,
    parameter  logic [CHR_W-1:0] EMPTY_CHR = 8'h2E,
    localparam int               IDX_W     = $clog2(COLS + 1),
    localparam int               LINE_W    = COLS * CHR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [CHR_W-1:0]  wr_chr_i,
    input  logic              flush_i,
    output logic [LINE_W-1:0] line_o
);

    for (genvar col = 0; col < COLS; col++) begin : g_col
        logic [CHR_W-1:0] buf_d, buf_q;
        logic [CHR_W-1:0] out_d, out_q;
        logic             hit;

        always_comb begin
            hit   = wr_en_i && (wr_idx_i == IDX_W'(col));
            buf_d = buf_q;
            out_d = out_q;
            if (flush_i) begin
                // hand the gathered row over and start the next one blank
                out_d = buf_q;
                buf_d = EMPTY_CHR;
            end else if (hit) begin
                buf_d = wr_chr_i;
            end
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                buf_q <= EMPTY_CHR;
                out_q <= EMPTY_CHR;
            end else begin
                buf_q <= buf_d;
                out_q <= out_d;
            end
        end

        assign line_o[col*CHR_W +: CHR_W] = out_q;
    end

endmodule

// File: rtl/lc_cell_dec.sv
module lc_cell_dec
    import line_cap_pkg::*;
#(
    parameter  int               COLS      = 256,
    parameter  logic [CHR_W-1:0] EMPTY_CHR = 8'h2E,
    parameter  logic [CHR_W-1:0] SRC_CHR   = 8'h53,
    parameter  logic [CHR_W-1:0] SPLIT_CHR = 8'h5E,
    localparam int               LINE_W    = COLS * CHR_W,
    localparam int               CODE_W    = COLS * CELL_W
) (
    input  logic [LINE_W-1:0] line_i,
    output logic [CODE_W-1:0] cell_o
);

    for (genvar col = 0; col < COLS; col++) begin : g_dec
        cell_e code;

        always_comb begin
            unique case (line_i[col*CHR_W +: CHR_W])
                EMPTY_CHR: code = CELL_EMPTY;
                SRC_CHR:   code = CELL_SOURCE;
                SPLIT_CHR: code = CELL_SPLIT;
                default:   code = CELL_OTHER;
            endcase
        end

        assign cell_o[col*CELL_W +: CELL_W] = code;
    end

endmodule

// File: rtl/line_capture.sv
module line_capture
    import line_cap_pkg::*;
#(
    parameter  int               COLS      = 256,
    parameter  logic [CHR_W-1:0] EMPTY_CHR = 8'h2E,
    parameter  logic [CHR_W-1:0] SRC_CHR   = 8'h53,
    parameter  logic [CHR_W-1:0] SPLIT_CHR = 8'h5E,
    localparam int               LINE_W    = COLS * CHR_W,
    localparam int               CODE_W    = COLS * CELL_W,
    localparam int               IDX_W     = $clog2(COLS + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CHR_W-1:0]  byte_i,
    input  logic              byte_vld_i,
    output logic [LINE_W-1:0] line_o,
    output logic [CODE_W-1:0] cell_o,
    output logic              start_o,
    output logic              ovf_o
);

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             flush;

    lc_ctrl #(
        .COLS (COLS)
    ) i_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .byte_i     (byte_i),
        .byte_vld_i (byte_vld_i),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .flush_o    (flush),
        .start_o    (start_o),
        .ovf_o      (ovf_o)
    );

    lc_store #(
        .COLS      (COLS),
        .EMPTY_CHR (EMPTY_CHR)
    ) i_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_chr_i (byte_i),
        .flush_i  (flush),
        .line_o   (line_o)
    );

    lc_cell_dec #(
        .COLS      (COLS),
        .EMPTY_CHR (EMPTY_CHR),
        .SRC_CHR   (SRC_CHR),
        .SPLIT_CHR (SPLIT_CHR)
    ) i_dec (
        .line_i (line_o),
        .cell_o (cell_o)
    );

endmodule

// File: rtl/lc_chk.sv
module lc_chk
    import line_cap_pkg::*;
#(
    parameter int LINE_W = 2048
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CHR_W-1:0]  byte_i,
    input logic              byte_vld_i,
    input logic [LINE_W-1:0] line_o,
    input logic              start_o,
    input logic              ovf_o
);

    // R3
    lf_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_vld_i && byte_i == LF_CHR) |=> start_o);

    // R3
    no_spurious_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(byte_vld_i && byte_i == LF_CHR) |=> !start_o);

    // R4
    line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_o |-> $stable(line_o));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> ovf_o);

    // R8
    ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_o) |-> $past(byte_vld_i));

endmodule

bind line_capture lc_chk #(
    .LINE_W (LINE_W)
) i_lc_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_i     (byte_i),
    .byte_vld_i (byte_vld_i),
    .line_o     (line_o),
    .start_o    (start_o),
    .ovf_o      (ovf_o)
);

// File: tb/test_line_capture.sv
module test_line_capture;

    localparam int COLS = 256;
    localparam int LW   = COLS * 8;
    localparam int CW   = COLS * 2;

    typedef logic [7:0] bq_t[$];

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    byte_in = 8'h00;
    logic          vld = 1'b0;
    logic [LW-1:0] line;
    logic [CW-1:0] cells;
    logic          start;
    logic          ovf;

    int            n_cmp = 0;
    int            n_bad = 0;
    logic [LW-1:0] exp_q[$];
    logic [LW-1:0] last_line;
    logic [LW-1:0] e_mon;

    always #5 clk = ~clk;

    line_capture i_line_capture (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .byte_i     (byte_in),
        .byte_vld_i (vld),
        .line_o     (line),
        .cell_o     (cells),
        .start_o    (start),
        .ovf_o      (ovf)
    );

    function automatic logic [CW-1:0] cells_of(input logic [LW-1:0] l);
        logic [CW-1:0] r;
        r = '0;
        for (int c = 0; c < COLS; c++) begin
            case (l[8*c +: 8])
                8'h2E:   r[2*c +: 2] = 2'd0;
                8'h53:   r[2*c +: 2] = 2'd1;
                8'h5E:   r[2*c +: 2] = 2'd2;
                default: r[2*c +: 2] = 2'd3;
            endcase
        end
        return r;
    endfunction

    function automatic bq_t str_q(input string s);
        bq_t r;
        for (int i = 0; i < s.len(); i++) r.push_back(s[i]);
        return r;
    endfunction

    function automatic logic [LW-1:0] expect_of(input bq_t q);
        logic [LW-1:0] e;
        int            pos;
        e   = {COLS{8'h2E}};
        pos = 0;
        foreach (q[i]) begin
            if (q[i] != 8'h0D) begin
                if (pos < COLS) e[8*pos +: 8] = q[i];
                pos++;
            end
        end
        return e;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input int gap);
        byte_in = b;
        vld     = 1'b1;
        @(negedge clk);
        vld = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_line(input bq_t q, input int gap);
        exp_q.push_back(expect_of(q));
        foreach (q[i]) push(q[i], gap);
        push(8'h0A, gap);
    endtask

    function automatic bq_t pattern_q(input int n);
        bq_t         r;
        logic [7:0]  pal [4];
        pal = '{8'h2E, 8'h53, 8'h5E, 8'h41};
        for (int i = 0; i < n; i++) r.push_back(pal[(i * 7 + i / 3) % 4]);
        return r;
    endfunction

    // Monitor: every start pulse consumes one expected line (R3, R9)
    always @(negedge clk) begin
        if (rst_n && start) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R3 start with no line sent: actual 1 expected 0");
            end else begin
                e_mon = exp_q.pop_front();
                check("R3", "line at start", line, e_mon);
                check("R9", "cell codes", LW'(cells), LW'(cells_of(e_mon)));
                last_line = e_mon;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bq_t q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", "line after reset", line, {COLS{8'h2E}});
        check("R1", "cells after reset", LW'(cells), '0);
        check("R1", "start after reset", LW'(start), '0);
        check("R1", "ovf after reset", LW'(ovf), '0);

        // R2 R3 R9 back-to-back characters
        send_line(str_q("S.^x"), 0);
        // R7 idle gaps between every byte
        send_line(str_q(".^^.S"), 6);

        // R7 long pause in mid-line leaves outputs untouched
        exp_q.push_back(expect_of(str_q("abc")));
        push(8'h61, 0);
        push(8'h62, 30);
        check("R7", "line during pause", line, last_line);
        check("R7", "start during pause", LW'(start), '0);
        push(8'h63, 2);
        push(8'h0A, 1);

        // R6 carriage returns inside and at end of a line
        send_line(str_q("x\ry\r"), 0);

        // R5 empty line clears every column
        q = {};
        send_line(q, 1);

        // R4 hold between pulses
        repeat (20) @(negedge clk);
        check("R4", "line held", line, last_line);

        // R5 short line after a long one
        send_line(str_q("SSSS^^^^xyz"), 0);
        send_line(str_q("^"), 0);

        // R8 exactly full line does not overflow
        send_line(pattern_q(256), 0);
        repeat (2) @(negedge clk);
        check("R8", "ovf after 256 chars", LW'(ovf), '0);

        // R8 over-long line is truncated and flags overflow
        send_line(pattern_q(300), 0);
        repeat (2) @(negedge clk);
        check("R8", "ovf after 300 chars", LW'(ovf), LW'(1));

        // R8 flag stays set; next line R5 fills from column 0
        send_line(str_q(".S"), 0);
        repeat (5) @(negedge clk);
        check("R8", "ovf sticky", LW'(ovf), LW'(1));
        check("R3", "lines without start", LW'(exp_q.size()), '0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule